// File: doc/BRIEF.md
# Push-Button Program Image Selector

This block picks which of three 16-bit program images a small processor fetches its instructions from. Image 0 sits in the original program ROM. Images 1 and 2 share a pair of byte-wide flash devices. One flash device holds the opcode byte of every word and the other holds the operand byte. Each flash device is split into two 64K-word banks, and one extra address bit chooses the bank.

An operator steps through the images with a select push-button. A second push-button resets the system. Both buttons are raw mechanical contacts, so each is synchronised and debounced. A one-hot modulo-3 ring holds the active image. From the ring the block derives three things:
- the active-low enable for the original ROM;
- a single active-low enable shared by both flash devices;
- the flash bank bit, which is placed on top of the fetch address.

Three LEDs show which image is live. Every image change asserts the system reset for a fixed time, so the processor restarts at address 0 of the new image.

Top module: `rom_image_selector`

## Requirements
- R1: While `rst_ni` is low and right after it rises, image 0 is active: `led_o`=3'b001, `rom_ce_no`=0, `flash_ce_no`=1, `bank_o`=0 and `sys_rst_no`=0.
- R2: Each accepted select press advances the image in the order 0, 1, 2, 0, … (`led_o` rotates 001 → 010 → 100 → 001).
- R3: A button level is accepted only after the synchronised input holds it for 2^DB_W consecutive clocks. A select pulse of 2^DB_W−1 clocks or less leaves the image unchanged.
- R4: The image advances only on the accepted press edge. Holding the button down does not repeat the step, and releasing it does not step either.
- R5: Image 0 drives `rom_ce_no`=0 and `flash_ce_no`=1. Images 1 and 2 drive `rom_ce_no`=1 and `flash_ce_no`=0, with `bank_o`=0 for image 1 and `bank_o`=1 for image 2.
- R6: At every clock exactly one of `rom_ce_no` and `flash_ce_no` is low, including the cycle in which the image changes.
- R7: `led_o` is one-hot, and bit i is set when image i is active.
- R8: `flash_addr_o` equals `{bank_o, fetch_addr_i}`. The bank bit is the MSB.
- R9: `sys_rst_no` is low while the debounced reset button is pressed. A reset-button pulse of 2^DB_W−1 clocks or less does not assert it.
- R10: An image change drives `sys_rst_no` low in the same cycle the enables and LEDs change, and keeps it low for RST_HOLD cycles when the reset button is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| sel_btn_i | input | 1 | Raw select button, high while pressed |
| rst_btn_i | input | 1 | Raw reset button, high while pressed |
| fetch_addr_i | input | ADDR_W | Processor fetch address |
| rom_ce_no | output | 1 | Original ROM enable, active low |
| flash_ce_no | output | 1 | Shared enable for both flash devices, active low |
| bank_o | output | 1 | Flash bank select bit |
| flash_addr_o | output | ADDR_W+1 | Flash address, bank bit on top of the fetch address |
| sys_rst_no | output | 1 | System reset to the processor, active low |
| led_o | output | 3 | Active-image indicators, one-hot |

## Verification
A ring that takes a wrong value shows up at once as a non-one-hot LED pattern or as overlapping enables on the very next clock. A ring that skips or repeats a step shows as a wrong image after a single press. A debouncer with an off-by-one counter shows when a pulse exactly one clock shorter than the acceptance window still moves the image or the reset line. A misaligned restart counter shows up in two ways:
- an enable or LED change while `sys_rst_no` is high;
- a reset pulse whose length is not RST_HOLD, measured in the cycles right after the change.

// File: rtl/rom_sel_pkg.sv
package rom_sel_pkg;
  localparam int unsigned NUM_IMG = 3;

  typedef enum logic [NUM_IMG-1:0] {
    IMG0 = 3'b001,
    IMG1 = 3'b010,
    IMG2 = 3'b100
  } img_e;
endpackage

// File: rtl/rom_sel_debounce.sv
module rom_sel_debounce #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CNT_W-1:0]       cnt_q;
  logic                   level_q, level_d1_q;

  // Synchroniser chain; stage 0 samples the raw contact.
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= raw_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end
  assign synced = sync_q[SYNC_STAGES-1];

  // Accept on the 2^CNT_W-th consecutive differing cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (synced == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_q   <= '0;
      level_q <= synced;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) level_d1_q <= 1'b0;
    else         level_d1_q <= level_q;

  assign level_o = level_q;
  assign rise_o  = level_q & ~level_d1_q;
endmodule

// File: rtl/rom_sel_ring.sv
module rom_sel_ring
  import rom_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output img_e img_o
);
  img_e img_q, img_d;

  always_comb begin
    unique case (img_q)
      IMG0:    img_d = IMG1;
      IMG1:    img_d = IMG2;
      default: img_d = IMG0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    img_q <= IMG0;
    else if (adv_i) img_q <= img_d;

  assign img_o = img_q;
endmodule

// File: rtl/rom_sel_restart.sv
module rom_sel_restart #(
  parameter int unsigned RST_HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic btn_i,
  output logic sys_rst_no
);
  localparam int unsigned HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_VAL = HOLD_W'(RST_HOLD);

  logic [HOLD_W-1:0] cnt_q;
  logic              rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= HOLD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  // Registered so it lines up with the registered enables.
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rst_n_q <= 1'b0;
    else         rst_n_q <= ~((cnt_q != '0) | btn_i);

  assign sys_rst_no = rst_n_q;
endmodule

// File: rtl/rom_sel_decode.sv
module rom_sel_decode
  import rom_sel_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  img_e                 img_i,
  output logic                 rom_ce_no,
  output logic                 flash_ce_no,
  output logic                 bank_o,
  output logic [NUM_IMG-1:0]   led_o
);
  logic rom_en, flash_en, bank;

  always_comb begin
    rom_en   = 1'b0;
    flash_en = 1'b0;
    bank     = 1'b0;
    unique case (img_i)
      IMG0: rom_en = 1'b1;
      IMG1: flash_en = 1'b1;
      default: begin
        flash_en = 1'b1;
        bank     = 1'b1;
      end
    endcase
  end

  // One register stage: enables switch atomically on a single edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_ce_no   <= 1'b0;
      flash_ce_no <= 1'b1;
      bank_o      <= 1'b0;
      led_o       <= IMG0;
    end else begin
      rom_ce_no   <= ~rom_en;
      flash_ce_no <= ~flash_en;
      bank_o      <= bank;
      led_o       <= img_i;
    end
  end
endmodule

// File: rtl/rom_image_selector.sv
module rom_image_selector
  import rom_sel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DB_W     = 16,
  parameter int unsigned RST_HOLD = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_btn_i,
  input  logic              rst_btn_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              rom_ce_no,
  output logic              flash_ce_no,
  output logic              bank_o,
  output logic [ADDR_W:0]   flash_addr_o,
  output logic              sys_rst_no,
  output logic [2:0]        led_o
);
  logic sel_level, sel_rise;
  logic rbtn_level, rbtn_rise;
  img_e img;

  rom_sel_debounce #(.CNT_W(DB_W)) u_sel_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (sel_btn_i),
    .level_o (sel_level),
    .rise_o  (sel_rise)
  );

  rom_sel_debounce #(.CNT_W(DB_W)) u_rst_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (rst_btn_i),
    .level_o (rbtn_level),
    .rise_o  (rbtn_rise)
  );

  rom_sel_ring u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (sel_rise),
    .img_o  (img)
  );

  rom_sel_restart #(.RST_HOLD(RST_HOLD)) u_restart (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sel_rise),
    .btn_i      (rbtn_level),
    .sys_rst_no (sys_rst_no)
  );

  rom_sel_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .img_i       (img),
    .rom_ce_no   (rom_ce_no),
    .flash_ce_no (flash_ce_no),
    .bank_o      (bank_o),
    .led_o       (led_o)
  );

  assign flash_addr_o = {bank_o, fetch_addr_i};

  logic unused_rise;
  assign unused_rise = rbtn_rise ^ sel_level;
endmodule

// File: rtl/rom_sel_checks.sv
module rom_sel_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rom_ce_no,
  input logic       flash_ce_no,
  input logic       bank_o,
  input logic       sys_rst_no,
  input logic [2:0] led_o
);
  // R6
  one_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_no != flash_ce_no);

  // R7
  led_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(led_o));

  // R5
  rom_led_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_ce_no) == led_o[0]);

  // R5
  bank_led_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_ce_no |-> (bank_o == led_o[2]));

  // R10
  change_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o) |-> !sys_rst_no);

  // R2
  rotate_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o) |-> (led_o == {$past(led_o[1:0]), $past(led_o[2])}));
endmodule

bind rom_image_selector rom_sel_checks u_rom_sel_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rom_ce_no   (rom_ce_no),
  .flash_ce_no (flash_ce_no),
  .bank_o      (bank_o),
  .sys_rst_no  (sys_rst_no),
  .led_o       (led_o)
);

// File: tb/rom_image_selector_bench.sv
module rom_image_selector_bench;
  localparam int ADDR_W = 16;
  localparam int DB_W   = 3;
  localparam int WIN    = 1 << DB_W;
  localparam int HOLD   = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_btn = 1'b0;
  logic              rst_btn = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              rom_ce_no, flash_ce_no, bank_o, sys_rst_no;
  logic [ADDR_W:0]   flash_addr;
  logic [2:0]        led;

  int n_chk = 0;
  int n_bad = 0;
  int img   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rom_image_selector #(.ADDR_W(ADDR_W), .DB_W(DB_W), .RST_HOLD(HOLD)) u_rom_image_selector (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sel_btn_i    (sel_btn),
    .rst_btn_i    (rst_btn),
    .fetch_addr_i (fetch_addr),
    .rom_ce_no    (rom_ce_no),
    .flash_ce_no  (flash_ce_no),
    .bank_o       (bank_o),
    .flash_addr_o (flash_addr),
    .sys_rst_no   (sys_rst_no),
    .led_o        (led)
  );

  function automatic logic [2:0] exp_led(int i);
    return 3'(1 << i);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    check({tag, " R7 led"}, 32'(led), 32'(exp_led(img)));
    check({tag, " R5 rom_ce"}, 32'(rom_ce_no), 32'(img != 0));
    check({tag, " R5 flash_ce"}, 32'(flash_ce_no), 32'(img == 0));
    check({tag, " R5 bank"}, 32'(bank_o), 32'(img == 2));
    check({tag, " R6 one enable"}, 32'(rom_ce_no ^ flash_ce_no), 32'd1);
  endtask

  // Monitor: reset pulse length after each image change (R10), low-cycle counter (R9).
  logic [2:0] led_prev = 3'b001;
  int run = 0;
  bit chg = 1'b0;
  int low_cycles = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!sys_rst_no) low_cycles++;
      if (led !== led_prev) begin
        check("R10 reset low at change", 32'(sys_rst_no), 32'd0);
        chg = 1'b1;
        run = 0;
      end
      if (chg) begin
        if (!sys_rst_no) run++;
        else begin
          if (!rst_btn) check("R10 hold length", 32'(run), 32'(HOLD));
          chg = 1'b0;
        end
      end
    end
    led_prev = led;
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int len);
    sel_btn = 1'b1;
    cycles(len);
    sel_btn = 1'b0;
    cycles(4 * WIN);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    cycles(3);
    // R1: values during reset
    check_outputs("R1 in reset");
    check("R1 sys_rst in reset", 32'(sys_rst_no), 32'd0);
    rst_ni = 1'b1;
    cycles(2);
    check_outputs("R1 after reset");
    check("R1 sys_rst released", 32'(sys_rst_no), 32'd1);

    // R2: full rotation with clean presses
    for (int k = 0; k < 4; k++) begin
      press(4 * WIN);
      img = (img + 1) % 3;
      check_outputs("R2 step");
    end

    // R3: pulse one clock short of the window is ignored
    press(WIN - 1);
    check_outputs("R3 short select");

    // R4: long hold advances exactly once
    sel_btn = 1'b1;
    cycles(20 * WIN);
    img = (img + 1) % 3;
    check_outputs("R4 held");
    sel_btn = 1'b0;
    cycles(4 * WIN);
    check_outputs("R4 release");

    // R9: reset button held and released, then a short glitch
    rst_btn = 1'b1;
    cycles(4 * WIN);
    check("R9 held reset", 32'(sys_rst_no), 32'd0);
    rst_btn = 1'b0;
    cycles(4 * WIN);
    check("R9 released reset", 32'(sys_rst_no), 32'd1);
    check_outputs("R9 image kept");
    low_cycles = 0;
    rst_btn = 1'b1;
    cycles(WIN - 1);
    rst_btn = 1'b0;
    cycles(4 * WIN);
    check("R9 glitch ignored", 32'(low_cycles), 32'd0);

    // Random mix of actions, checked against the model
    for (int it = 0; it < 60; it++) begin
      int act = int'($urandom_range(0, 3));
      fetch_addr = ADDR_W'($urandom());
      case (act)
        0: begin press(WIN + 2 + int'($urandom_range(0, 3 * WIN))); img = (img + 1) % 3; end
        1: press(int'($urandom_range(1, WIN - 1)));
        2: begin
          low_cycles = 0;
          rst_btn = 1'b1; cycles(int'($urandom_range(1, WIN - 1)));
          rst_btn = 1'b0; cycles(4 * WIN);
          check("R9 random glitch", 32'(low_cycles), 32'd0);
        end
        default: cycles(1);
      endcase
      check_outputs("R2 random");
      // R8: bank bit on top of the fetch address
      check("R8 flash addr", 32'(flash_addr), 32'({bank_o, fetch_addr}));
    end

    // R1: mid-run power-on reset returns to image 0
    if (img == 0) begin press(4 * WIN); img = 1; end
    rst_ni = 1'b0;
    cycles(2);
    img = 0;
    check_outputs("R1 re-reset");
    rst_ni = 1'b1;
    cycles(2);
    check_outputs("R1 after re-reset");

    finish_run();
  end
endmodule